// File: doc/BRIEF.md
# Mask test condition code unit

This block produces a 2-bit condition code for two mask-driven operations in a single combinational pass. In bit-test mode the unit ANDs the low bits of a value with a 16-bit mask and classifies the result as all-clear, all-set or mixed. A mixed result is split further by the value bit that sits under the most significant set mask bit.

In byte-insert mode the low four mask bits pick which byte lanes of a register are loaded. The code describes the bytes being inserted. The caller supplies those bytes already packed: they are right-justified in the value input and kept in mask order. The number of set mask bits gives how many of the low bytes are live. The first inserted byte is the most significant live byte, and its top bit gives the sign. Write-back of the inserted bytes happens elsewhere. Only the code is produced here.

The output follows the inputs within the same cycle. No state is held.

Top module: `mtcc_unit`

## Requirements
- R1: In bit-test mode (mode_i = 0), a zero mask gives code 0 whatever the value.
- R2: In bit-test mode with a nonzero mask, the code is 0 when value_i[15:0] AND mask_i is zero.
- R3: In bit-test mode with a nonzero mask, the code is 3 when every masked bit of value_i[15:0] is one.
- R4: In bit-test mode, a mixed result gives code 2 when the value bit under the highest set mask bit is one, and code 1 when it is zero.
- R5: In bit-test mode, value_i[31:16] has no effect on the code.
- R6: In byte-insert mode (mode_i = 1), mask_i[3:0] = 0 gives code 0, and mask_i[15:4] has no effect on the code.
- R7: In byte-insert mode with mask_i[3:0] = 4'b1111, the code is 0 for a zero value, 1 when bit 31 is set, and 2 otherwise.
- R8: In byte-insert mode with N = popcount(mask_i[3:0]) between 1 and 3, the live bytes are value_i[8N-1:0]. The code is 0 if they are all zero, 1 if bit 8N-1 is set, and 2 otherwise. Code 3 never occurs in this mode.
- R9: In byte-insert mode, value bits at and above position 8N do not affect the code.
- R10: mode_i selects between the two classifications, and cc_o reflects the present inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 1 | 0 = bit test under mask, 1 = byte insert under mask |
| value_i | input | 32 | Tested value (bit test) or packed, right-justified inserted bytes (byte insert) |
| mask_i | input | 16 | Bit mask (bit test); bits 3:0 are the byte lane mask (byte insert) |
| cc_o | output | 2 | Condition code 0..3 |

## Verification
The checker assumes that all inputs carry known values. Its properties are evaluated only when mode, value and mask contain no X or Z bits. The stimulus always drives fully defined words and changes them only away from the sampling point, so every property sees a settled combination. Byte-insert stimulus deliberately sets the upper mask bits and the value bits beyond the live bytes. This keeps the properties meaningful where they would otherwise be satisfied trivially.

// File: rtl/mtcc_pkg.sv
package mtcc_pkg;

  typedef enum logic {
    MODE_BIT_TEST = 1'b0,
    MODE_BYTE_INS = 1'b1
  } mtcc_mode_e;

  localparam logic [1:0] CC_ZERO  = 2'd0;
  localparam logic [1:0] CC_LOW   = 2'd1;
  localparam logic [1:0] CC_HIGH  = 2'd2;
  localparam logic [1:0] CC_FULL  = 2'd3;

endpackage

// File: rtl/mtcc_bit_test.sv
module mtcc_bit_test
  import mtcc_pkg::*;
#(
  parameter int TEST_W = 16
) (
  input  logic [TEST_W-1:0]         value_i,
  input  logic [TEST_W-1:0]         mask_i,
  output logic [1:0]                cc_o,
  output logic [$clog2(TEST_W)-1:0] lead_idx_o,
  output logic                      lead_bit_o,
  output logic                      mixed_o
);

  localparam int IDX_W = $clog2(TEST_W);

  // priority encoder: index of the highest set bit, 0 when none
  function automatic logic [IDX_W-1:0] top_set(input logic [TEST_W-1:0] m);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < TEST_W; i++) begin
      if (m[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  logic [TEST_W-1:0] picked;
  logic              none_set;
  logic              all_set;

  assign picked     = value_i & mask_i;
  assign none_set   = (mask_i == '0) || (picked == '0);
  assign all_set    = (picked == mask_i);
  assign lead_idx_o = top_set(mask_i);
  assign lead_bit_o = value_i[lead_idx_o];
  assign mixed_o    = !none_set && !all_set;

  always_comb begin
    if (none_set)       cc_o = CC_ZERO;
    else if (all_set)   cc_o = CC_FULL;
    else if (lead_bit_o) cc_o = CC_HIGH;
    else                cc_o = CC_LOW;
  end

endmodule

// File: rtl/mtcc_byte_insert.sv
module mtcc_byte_insert
  import mtcc_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0]     data_i,
  input  logic [LANES-1:0]            mask_i,
  output logic [1:0]                  cc_o,
  output logic [$clog2(LANES+1)-1:0]  count_o,
  output logic                        live_nz_o,
  output logic                        lead_sign_o
);

  localparam int CNT_W = $clog2(LANES+1);

  function automatic logic [CNT_W-1:0] ones(input logic [LANES-1:0] m);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int j = 0; j < LANES; j++) n = n + CNT_W'(m[j]);
    return n;
  endfunction

  logic [LANES-1:0] lane_nz;
  logic [LANES-1:0] lane_sign;
  logic [LANES-1:0] lane_live;

  assign count_o = ones(mask_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_nz[g]   = |data_i[g*LANE_W +: LANE_W];
    assign lane_sign[g] = data_i[g*LANE_W + LANE_W - 1];
    assign lane_live[g] = (count_o > CNT_W'(g));
  end

  assign live_nz_o = |(lane_nz & lane_live);

  // sign of the most significant live lane (lane count-1)
  always_comb begin
    lead_sign_o = 1'b0;
    for (int j = 0; j < LANES; j++) begin
      if (count_o == CNT_W'(j + 1)) lead_sign_o = lane_sign[j];
    end
  end

  always_comb begin
    if (count_o == '0 || !live_nz_o) cc_o = CC_ZERO;
    else if (lead_sign_o)            cc_o = CC_LOW;
    else                             cc_o = CC_HIGH;
  end

endmodule

// File: rtl/mtcc_unit.sv
module mtcc_unit
  import mtcc_pkg::*;
#(
  parameter int TEST_W = 16,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                                                    mode_i,
  input  logic [((TEST_W > LANES*LANE_W) ? TEST_W : LANES*LANE_W)-1:0] value_i,
  input  logic [TEST_W-1:0]                                       mask_i,
  output logic [1:0]                                              cc_o
);

  localparam int INS_W = LANES * LANE_W;
  localparam int VAL_W = (TEST_W > INS_W) ? TEST_W : INS_W;
  localparam int IDX_W = $clog2(TEST_W);
  localparam int CNT_W = $clog2(LANES + 1);

  mtcc_mode_e        mode;
  logic [1:0]        bt_cc;
  logic [IDX_W-1:0]  bt_lead_idx;
  logic              bt_lead_bit;
  logic              bt_mixed;
  logic [1:0]        bi_cc;
  logic [CNT_W-1:0]  bi_count;
  logic              bi_live_nz;
  logic              bi_lead_sign;

  assign mode = mtcc_mode_e'(mode_i);

  mtcc_bit_test #(.TEST_W(TEST_W)) i_bit_test (
    .value_i    (value_i[TEST_W-1:0]),
    .mask_i     (mask_i),
    .cc_o       (bt_cc),
    .lead_idx_o (bt_lead_idx),
    .lead_bit_o (bt_lead_bit),
    .mixed_o    (bt_mixed)
  );

  mtcc_byte_insert #(.LANES(LANES), .LANE_W(LANE_W)) i_byte_insert (
    .data_i      (value_i[INS_W-1:0]),
    .mask_i      (mask_i[LANES-1:0]),
    .cc_o        (bi_cc),
    .count_o     (bi_count),
    .live_nz_o   (bi_live_nz),
    .lead_sign_o (bi_lead_sign)
  );

  assign cc_o = (mode == MODE_BYTE_INS) ? bi_cc : bt_cc;

endmodule

// File: rtl/mtcc_unit_chk.sv
module mtcc_unit_chk #(
  parameter int TEST_W = 16,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input logic                                                    mode_i,
  input logic [((TEST_W > LANES*LANE_W) ? TEST_W : LANES*LANE_W)-1:0] value_i,
  input logic [TEST_W-1:0]                                       mask_i,
  input logic [1:0]                                              cc_o,
  input logic                                                    bt_mixed,
  input logic                                                    bt_lead_bit,
  input logic [$clog2(LANES+1)-1:0]                              bi_count,
  input logic                                                    bi_live_nz
);

  localparam int INS_W = LANES * LANE_W;

  always_comb begin
    if (!$isunknown({mode_i, value_i, mask_i})) begin
      p_zero_mask_r1: assert (!(!mode_i && mask_i == '0) || cc_o == 2'd0)
        else $error("zero mask in bit test did not give code 0");
      p_all_ones_r3: assert (!(!mode_i && mask_i != '0 &&
                               (value_i[TEST_W-1:0] & mask_i) == mask_i) || cc_o == 2'd3)
        else $error("fully selected bit test did not give code 3");
      p_mixed_r4: assert (!(!mode_i && bt_mixed) ||
                          cc_o == (bt_lead_bit ? 2'd2 : 2'd1))
        else $error("mixed bit test code does not follow leading bit");
      p_empty_lanes_r6: assert (!(mode_i && mask_i[LANES-1:0] == '0) || cc_o == 2'd0)
        else $error("empty lane mask did not give code 0");
      p_full_sign_r7: assert (!(mode_i && (&mask_i[LANES-1:0]) && value_i[INS_W-1]) ||
                              cc_o == 2'd1)
        else $error("full insert with sign bit did not give code 1");
      p_no_three_r8: assert (!mode_i || cc_o != 2'd3)
        else $error("byte insert produced code 3");
      p_lane_count_r8: assert (!mode_i || bi_count == $countones(mask_i[LANES-1:0]))
        else $error("live lane count disagrees with mask");
      p_dead_zero_r9: assert (!(mode_i && !bi_live_nz) || cc_o == 2'd0)
        else $error("all live bytes zero but code nonzero");
    end
  end

endmodule

bind mtcc_unit mtcc_unit_chk #(.TEST_W(TEST_W), .LANES(LANES), .LANE_W(LANE_W)) i_chk (
  .mode_i      (mode_i),
  .value_i     (value_i),
  .mask_i      (mask_i),
  .cc_o        (cc_o),
  .bt_mixed    (bt_mixed),
  .bt_lead_bit (bt_lead_bit),
  .bi_count    (bi_count),
  .bi_live_nz  (bi_live_nz)
);

// File: tb/test_mtcc_unit.sv
module test_mtcc_unit;

  logic        clk = 1'b0;
  logic        mode;
  logic [31:0] value;
  logic [15:0] mask;
  logic [1:0]  cc;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mtcc_unit i_mtcc_unit (
    .mode_i  (mode),
    .value_i (value),
    .mask_i  (mask),
    .cc_o    (cc)
  );

  // behavioural reference built from the requirements
  function automatic int ref_cc(input logic m, input logic [31:0] v, input logic [15:0] k);
    int n;
    longint unsigned keep;
    if (!m) begin
      if (k == 16'h0 || (v[15:0] & k) == 16'h0) return 0;
      if ((v[15:0] & k) == k) return 3;
      for (int i = 15; i >= 0; i--) begin
        if (k[i]) return v[i] ? 2 : 1;
      end
      return 0;
    end
    n = 0;
    for (int i = 0; i < 4; i++) n += int'(k[i]);
    if (n == 0) return 0;
    keep = longint'(v) & ((64'd1 << (8 * n)) - 64'd1);
    if (keep == 0) return 0;
    return v[8 * n - 1] ? 1 : 2;
  endfunction

  task automatic apply(input logic m, input logic [31:0] v, input logic [15:0] k,
                       input string tag);
    int exp;
    @(negedge clk);
    mode  = m;
    value = v;
    mask  = k;
    #2;
    exp = ref_cc(m, v, k);
    checks++;
    if (cc !== exp[1:0]) begin
      errors++;
      $display("FAIL %s: mode=%0d value=%h mask=%h actual=%0d expected=%0d",
               tag, m, v, k, cc, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mode  = 1'b0;
    value = 32'h0;
    mask  = 16'h0;
    repeat (3) @(posedge clk);
    apply(1'b0, 32'h0, 16'h0, "R1 idle");

    apply(1'b0, 32'h0000_ffff, 16'h0000, "R1");
    apply(1'b0, 32'h0000_0f0f, 16'h00f0, "R2");
    apply(1'b0, 32'h0000_00f0, 16'h00f0, "R3");
    apply(1'b0, 32'h0000_ffff, 16'hffff, "R3");
    apply(1'b0, 32'h0000_0100, 16'h0180, "R4");
    apply(1'b0, 32'h0000_0080, 16'h0180, "R4");
    apply(1'b0, 32'h0000_0001, 16'h8001, "R4");
    apply(1'b0, 32'h0000_8000, 16'h8001, "R4");
    apply(1'b0, 32'hffff_0000, 16'h00ff, "R5");
    apply(1'b0, 32'hffff_00ff, 16'h00ff, "R5");
    apply(1'b1, 32'hffff_ffff, 16'h0000, "R6");
    apply(1'b1, 32'hffff_ffff, 16'hfff0, "R6");
    apply(1'b1, 32'h0000_0000, 16'h000f, "R7");
    apply(1'b1, 32'h8000_0000, 16'h000f, "R7");
    apply(1'b1, 32'h7fff_ffff, 16'h000f, "R7");
    apply(1'b1, 32'h0000_0080, 16'h0001, "R8");
    apply(1'b1, 32'h0000_007f, 16'h0001, "R8");
    apply(1'b1, 32'h0000_8000, 16'h0005, "R8");
    apply(1'b1, 32'h0000_0080, 16'h0005, "R8");
    apply(1'b1, 32'h0080_0000, 16'h000e, "R8");
    apply(1'b1, 32'hffff_ff00, 16'h0001, "R9");
    apply(1'b1, 32'hff00_0000, 16'h0003, "R9");
    apply(1'b1, 32'h8000_0001, 16'h0004, "R9");
    apply(1'b0, 32'h0000_00ff, 16'h000f, "R10");
    apply(1'b1, 32'h0000_00ff, 16'h000f, "R10");

    for (int t = 0; t < 400; t++) begin
      logic [15:0] k;
      logic [31:0] v;
      v = $urandom;
      case (t % 4)
        0: k = 16'($urandom);
        1: k = 16'(1) << ($urandom % 16);
        2: k = 16'($urandom) & 16'($urandom);
        default: k = 16'($urandom) | 16'h000f;
      endcase
      if (t % 5 == 0) v = v & 32'h0000_00ff;
      apply(1'($urandom), v, k, "R10 sweep");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule